// File: doc/BRIEF.md
# Reset Mode and Configuration Latch

This block settles how a small controller comes out of reset. Two mode pins are sampled while reset is held. The value seen on the last reset clock edge selects one of four operating modes: single chip, expanded, bootstrap or special test. That value is held until the next reset. The block keeps a three-bit status register holding a boot-ROM enable, a special-mode flag and a mode-select bit. Each of these bits has its own write rule, and the rule depends on the current mode.

A configuration latch loads its bits from a nonvolatile byte on every reset. Software reading the configuration register sees that latched value, not the last value written. Writes reach the latch directly only while the special-mode flag is set. On the way out of reset the latch forces the ROM placement and enable bits as the mode demands. The latched and status bits drive decoded control outputs for the rest of the chip. Software reaches both registers through a byte-wide port: one select line, a write strobe and a combinational read path.

Top module: `rmc_top`

## Requirements
- R1: The pin pair {mode_pin_b, mode_pin_a} present at the last rising clock edge with rst_n low is captured and shown on op_mode. The encodings are 2'b10 single chip, 2'b11 expanded, 2'b00 bootstrap and 2'b01 special test. Pin changes after reset release have no effect on op_mode or on any register.
- R2: After reset the status register (reg_sel=0) reads as follows. Bit 6 (special) equals the inverse of mode pin B. Bit 5 (mode select) equals mode pin A. Bit 7 (boot-ROM enable) is 1 only in bootstrap. Bits 4:0 always read 0.
- R3: A status write can clear bit 6 but never set it.
- R4: Status bit 5 follows every status write made while bit 6 is set. While bit 6 is clear, only the first status write made in that condition since reset changes bit 5. Later writes leave it unchanged.
- R5: Status bit 7 is written only when bit 6 is set before the write. Otherwise it keeps its value.
- R6: The configuration register (reg_sel=1) reads the value latched from nv_cfg at the last reset. Writes made while status bit 6 is clear have no effect. A changed nv_cfg becomes visible only after the next reset.
- R7: While status bit 6 is set, a configuration write replaces bits 4:0 in the next cycle.
- R8: Configuration bits 7:5 always read 1.
- R9: On reset, configuration bit 3 (ROM in upper region) and bit 2 (ROM on) are forced to 1 in single chip. Bit 2 is forced to 0 in special test.
- R10: special_mode, mode_a and boot_rom_en mirror status bits 6, 5 and 7. clk_out_en, rom_upper, rom_on, wdog_off and nvm_en mirror configuration bits 4, 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin_b | input | 1 | Mode pin B, sampled during reset |
| mode_pin_a | input | 1 | Mode pin A, sampled during reset |
| nv_cfg | input | 5 | Nonvolatile configuration bits, loaded on reset |
| reg_sel | input | 1 | 0 selects status, 1 selects configuration |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the selected register |
| op_mode | output | 2 | Captured mode pins {B,A} |
| special_mode | output | 1 | Special-mode flag |
| mode_a | output | 1 | Mode-select bit |
| boot_rom_en | output | 1 | Boot ROM enable |
| clk_out_en | output | 1 | Clock output enable |
| rom_upper | output | 1 | ROM placed in upper region |
| rom_on | output | 1 | ROM present in the map |
| wdog_off | output | 1 | Watchdog disabled |
| nvm_en | output | 1 | Nonvolatile array present in the map |

## Verification
The assertions check, on every cycle, the rules that must always hold. The captured mode stays stable. The special flag never rises. The boot-ROM enable and the configuration latch stay frozen outside special mode. The mode-select bit stays frozen once its single normal-mode write is spent. The ROM bits are forced on the cycle after a single-chip reset. Only the bench can show that reset values follow each pin combination and nonvolatile byte. It also shows that the one allowed normal-mode write actually lands, that special writes after leaving special mode are refused, and that a new nonvolatile value appears only after another reset.

// File: rtl/rmc_pkg.sv
// Shared types and bit positions for the reset mode and configuration latch.
package rmc_pkg;

    // Operating mode as the captured pin pair {B,A}.
    typedef enum logic [1:0] {
        MODE_BOOT   = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_SINGLE = 2'b10,
        MODE_EXP    = 2'b11
    } op_mode_e;

    // Configuration bit positions inside the implemented field.
    localparam int CF_NVM_EN  = 0;
    localparam int CF_WD_OFF  = 1;
    localparam int CF_ROM_ON  = 2;
    localparam int CF_ROM_HI  = 3;
    localparam int CF_CLK_OUT = 4;

    // Number of status bits, packed at the top of the data byte.
    localparam int ST_W = 3;

endpackage

// File: rtl/rmc_mode_capture.sv
// Mode pin capture.
// Samples the two mode pins on every clock edge while reset is low, and
// holds the last sample once reset is released.
// Assumes the pins are stable around the edge where reset deasserts.
module rmc_mode_capture
    import rmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_b,
    input  logic     pin_a,
    output op_mode_e mode_d,
    output op_mode_e mode_q
);

    assign mode_d = op_mode_e'({pin_b, pin_a});

    // Track the pins only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_d;
        end
    end

    // R1: the captured mode never moves outside reset.
    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

endmodule

// File: rtl/rmc_status_reg.sv
// Mode status register.
// Holds the boot-ROM enable, special flag and mode-select bits.
// Reset values follow the live mode pins during reset.
// Write rules: the special flag can only be cleared.
// Boot enable and mode select are freely writable while special.
// Outside special, mode select takes one write per reset.
// Assumes the write strobe is one cycle per access.
module rmc_status_reg
    import rmc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  op_mode_e        mode_d,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wr_bits,   // {boot, special, mode_a}
    output logic            boot_o,
    output logic            special_o,
    output logic            mode_a_o
);

    localparam int W_BOOT = ST_W - 1;
    localparam int W_SPEC = ST_W - 2;
    localparam int W_MDA  = ST_W - 3;

    logic boot_q, spec_q, mda_q, mda_done_q;

    // Reset from the mode pins, then apply the mode-dependent write rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q     <= (mode_d == MODE_BOOT);
            spec_q     <= ~mode_d[1];
            mda_q      <= mode_d[0];
            mda_done_q <= 1'b0;
        end else if (wr_en) begin
            if (!wr_bits[W_SPEC]) begin
                spec_q <= 1'b0;
            end
            if (spec_q) begin
                boot_q <= wr_bits[W_BOOT];
                mda_q  <= wr_bits[W_MDA];
            end else begin
                if (!mda_done_q) begin
                    mda_q <= wr_bits[W_MDA];
                end
                mda_done_q <= 1'b1;
            end
        end
    end

    assign boot_o    = boot_q;
    assign special_o = spec_q;
    assign mode_a_o  = mda_q;

    // R3: once clear, the special flag stays clear until reset.
    a_r3_special_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(spec_q) |-> !spec_q);

    // R5: boot enable is frozen while not special.
    a_r5_boot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(spec_q) |-> $stable(boot_q));

    // R4: after the single normal-mode write, mode select is frozen.
    a_r4_mda_once: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(spec_q) && $past(mda_done_q) |-> $stable(mda_q));

endmodule

// File: rtl/rmc_cfg_latch.sv
// Configuration shadow latch.
// Loads the implemented configuration bits from the nonvolatile input on
// every reset cycle.
// ROM placement and enable are forced according to the mode.
// Direct writes are taken only while the special flag is set.
// Assumes IMPL_W covers the ROM bit positions from the package.
module rmc_cfg_latch
    import rmc_pkg::*;
#(
    parameter int IMPL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_mode_e          mode_d,
    input  logic [IMPL_W-1:0] nv_bits,
    input  logic              special_i,
    input  logic              wr_en,
    input  logic [IMPL_W-1:0] wr_bits,
    output logic [IMPL_W-1:0] cfg_q
);

    for (genvar i = 0; i < IMPL_W; i++) begin : g_bit
        logic rst_val;
        logic bit_q;

        if (i == CF_ROM_HI) begin : g_hi
            // Single chip forces ROM into the upper region.
            assign rst_val = nv_bits[i] | (mode_d == MODE_SINGLE);
        end else if (i == CF_ROM_ON) begin : g_on
            // Single chip forces ROM on; special test forces it off.
            assign rst_val = (nv_bits[i] | (mode_d == MODE_SINGLE))
                             & (mode_d != MODE_TEST);
        end else begin : g_plain
            assign rst_val = nv_bits[i];
        end

        // Reload on reset, direct write only in special mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= rst_val;
            end else if (wr_en && special_i) begin
                bit_q <= wr_bits[i];
            end
        end

        assign cfg_q[i] = bit_q;
    end

    // R6: outside special mode the latch never changes.
    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(special_i) |-> $stable(cfg_q));

    // R7: a special-mode write lands one cycle later.
    a_r7_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) && $past(special_i) |-> cfg_q == $past(wr_bits));

endmodule

// File: rtl/rmc_top.sv
// Reset mode and configuration latch, top level.
// Ties the mode capture, the status register and the configuration latch
// to a byte-wide register port: reg_sel=0 is status, reg_sel=1 is config.
// Read data is combinational. Assumes DATA_W >= CFG_IMPL_W + ST_W.
module rmc_top
    import rmc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CFG_IMPL_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_pin_b,
    input  logic                  mode_pin_a,
    input  logic [CFG_IMPL_W-1:0] nv_cfg,
    input  logic                  reg_sel,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    output logic [1:0]            op_mode,
    output logic                  special_mode,
    output logic                  mode_a,
    output logic                  boot_rom_en,
    output logic                  clk_out_en,
    output logic                  rom_upper,
    output logic                  rom_on,
    output logic                  wdog_off,
    output logic                  nvm_en
);

    localparam int CFG_PAD_W = DATA_W - CFG_IMPL_W;
    localparam int ST_PAD_W  = DATA_W - ST_W;

    op_mode_e              mode_d, mode_q;
    logic                  st_boot, st_spec, st_mda;
    logic [CFG_IMPL_W-1:0] cfg_q;
    logic [DATA_W-1:0]     status_rd, cfg_rd;

    rmc_mode_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_b  (mode_pin_b),
        .pin_a  (mode_pin_a),
        .mode_d (mode_d),
        .mode_q (mode_q)
    );

    rmc_status_reg u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_d    (mode_d),
        .wr_en     (wr_en && !reg_sel),
        .wr_bits   (wr_data[DATA_W-1 -: ST_W]),
        .boot_o    (st_boot),
        .special_o (st_spec),
        .mode_a_o  (st_mda)
    );

    rmc_cfg_latch #(.IMPL_W(CFG_IMPL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_d    (mode_d),
        .nv_bits   (nv_cfg),
        .special_i (st_spec),
        .wr_en     (wr_en && reg_sel),
        .wr_bits   (wr_data[CFG_IMPL_W-1:0]),
        .cfg_q     (cfg_q)
    );

    // Register images: status zero-padded below, config one-padded above.
    assign status_rd = {st_boot, st_spec, st_mda, {ST_PAD_W{1'b0}}};
    assign cfg_rd    = {{CFG_PAD_W{1'b1}}, cfg_q};

    // Read mux.
    always_comb begin
        rd_data = reg_sel ? cfg_rd : status_rd;
    end

    assign op_mode      = mode_q;
    assign special_mode = st_spec;
    assign mode_a       = st_mda;
    assign boot_rom_en  = st_boot;
    assign clk_out_en   = cfg_q[CF_CLK_OUT];
    assign rom_upper    = cfg_q[CF_ROM_HI];
    assign rom_on       = cfg_q[CF_ROM_ON];
    assign wdog_off     = cfg_q[CF_WD_OFF];
    assign nvm_en       = cfg_q[CF_NVM_EN];

    // R9: the first cycle after a single-chip reset has ROM forced up and on.
    a_r9_single_rom_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) && (mode_q == MODE_SINGLE) |-> rom_upper && rom_on);

    // R9: the first cycle after a special-test reset has ROM off.
    a_r9_test_rom_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) && (mode_q == MODE_TEST) |-> !rom_on);

    // R2: the special flag and the captured pin B disagree right after reset.
    a_r2_special_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> special_mode == !mode_q[1]);

endmodule

// File: tb/sim_rmc_top.sv
module sim_rmc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_pin_b = 1'b1, mode_pin_a = 1'b0;
    logic [4:0] nv_cfg = '0;
    logic       reg_sel = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] op_mode;
    logic special_mode, mode_a, boot_rom_en, clk_out_en, rom_upper, rom_on, wdog_off, nvm_en;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    rmc_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_pin_b(mode_pin_b), .mode_pin_a(mode_pin_a),
        .nv_cfg(nv_cfg), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .op_mode(op_mode), .special_mode(special_mode),
        .mode_a(mode_a), .boot_rom_en(boot_rom_en), .clk_out_en(clk_out_en),
        .rom_upper(rom_upper), .rom_on(rom_on), .wdog_off(wdog_off), .nvm_en(nvm_en)
    );

    // {pins B,A, nv_cfg, expected status, expected config}
    localparam logic [22:0] VEC [6] = '{
        {2'b10, 5'h00, 8'h00, 8'hEC},
        {2'b11, 5'h05, 8'h20, 8'hE5},
        {2'b00, 5'h0A, 8'hC0, 8'hEA},
        {2'b01, 5'h1F, 8'h60, 8'hFB},
        {2'b10, 5'h11, 8'h00, 8'hFD},
        {2'b01, 5'h04, 8'h60, 8'hE0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] pins, input logic [4:0] nv);
        @(negedge clk);
        rst_n = 1'b0;
        {mode_pin_b, mode_pin_a} = pins;
        nv_cfg = nv;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic sel, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        // Table walk: R1 R2 R6 R8 R9 reset images for every pin pair.
        for (int i = 0; i < 6; i++) begin
            do_reset(VEC[i][22:21], VEC[i][20:16]);
            chk("R1 op_mode", {6'b0, op_mode}, {6'b0, VEC[i][22:21]});
            rd_chk("R2 status reset", 1'b0, VEC[i][15:8]);
            rd_chk("R6 R8 R9 config reset", 1'b1, VEC[i][7:0]);
        end

        // R1: pin changes after release are ignored.
        do_reset(2'b11, 5'h00);
        {mode_pin_b, mode_pin_a} = 2'b00;
        repeat (3) @(negedge clk);
        chk("R1 pins ignored op_mode", {6'b0, op_mode}, 8'h03);
        rd_chk("R1 pins ignored status", 1'b0, 8'h20);

        // R3 R5 R4 in expanded: set attempts fail, mode_a takes one write.
        wr(1'b0, 8'hFF);
        rd_chk("R3 R5 expanded write", 1'b0, 8'h20);
        wr(1'b0, 8'h00);
        rd_chk("R4 second normal write", 1'b0, 8'h20);

        // R4 in single chip.
        do_reset(2'b10, 5'h00);
        wr(1'b0, 8'h20);
        rd_chk("R4 first normal write", 1'b0, 8'h20);
        wr(1'b0, 8'h00);
        rd_chk("R4 blocked write", 1'b0, 8'h20);

        // Special test: leave special, then one normal write.
        do_reset(2'b01, 5'h00);
        wr(1'b0, 8'h80);
        rd_chk("R3 R5 clear special set boot", 1'b0, 8'h80);
        wr(1'b0, 8'h20);
        rd_chk("R4 R5 first normal after special", 1'b0, 8'hA0);
        wr(1'b0, 8'h80);
        rd_chk("R4 R5 blocked after leave", 1'b0, 8'hA0);

        // Bootstrap: special writes any number of times.
        do_reset(2'b00, 5'h00);
        chk("R10 boot outputs", {5'b0, boot_rom_en, special_mode, mode_a}, 8'h06);
        wr(1'b0, 8'h40);
        rd_chk("R5 boot clear", 1'b0, 8'h40);
        wr(1'b0, 8'h60);
        rd_chk("R4 special mda set", 1'b0, 8'h60);
        wr(1'b0, 8'h40);
        rd_chk("R4 special mda clear", 1'b0, 8'h40);
        wr(1'b0, 8'hC0);
        rd_chk("R5 boot set in special", 1'b0, 8'hC0);

        // R6: normal writes and nv changes without reset are ignored.
        do_reset(2'b10, 5'h00);
        wr(1'b1, 8'h00);
        rd_chk("R6 normal cfg write", 1'b1, 8'hEC);
        nv_cfg = 5'h03;
        repeat (2) @(negedge clk);
        rd_chk("R6 nv change no reset", 1'b1, 8'hEC);
        do_reset(2'b11, 5'h03);
        rd_chk("R6 nv after reset", 1'b1, 8'hE3);

        // R7 R8 R10: special test direct writes.
        do_reset(2'b01, 5'h00);
        rd_chk("R9 test rom off", 1'b1, 8'hE0);
        wr(1'b1, 8'h0C);
        rd_chk("R7 R8 special cfg write", 1'b1, 8'hEC);
        chk("R10 cfg outputs", {3'b0, clk_out_en, rom_upper, rom_on, wdog_off, nvm_en}, 8'h0C);
        wr(1'b1, 8'h00);
        rd_chk("R7 special cfg clear", 1'b1, 8'hE0);
        chk("R10 rom_on output", {7'b0, rom_on}, 8'h00);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hFF);
        rd_chk("R6 cfg after leaving special", 1'b1, 8'hE0);
        chk("R10 special output", {7'b0, special_mode}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule